// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may go ahead, given the permission bits that a page-table walk has collected for the target page. The inputs are the access type (read, write or instruction fetch), the privilege of the access, and a set of control switches: write protection for supervisor code, honouring of the no-execute bit, supervisor execute prevention and supervisor access prevention on user pages, and per-key rights. For a present, well-formed leaf it returns three grant bits (read, write, execute) that a TLB can cache. If the attempted access is not granted, it also returns a page-fault error code with exact cause bits.

The walker gives one request per cycle with `req_valid`. One clock later the result appears on the `rsp_*` outputs with `rsp_valid` high. The result registers keep their last value while no request arrives. The walker also reports a leaf that was not present and a leaf with a reserved bit set. The checker turns each of these into the matching fault code.

Top module: `page_perm_check`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `rsp_fault`, all grant bits and `rsp_err` are zero, even if a request is driven during reset.
- R2: A request gives `rsp_valid` high in the next cycle only. In a cycle with no request, the grant, fault and error outputs keep their values.
- R3: A user access (`req_user`=1) to a page whose accumulated user bit is clear faults. All grants are zero and the error code has the protection bit (bit 0) set and the key bit (bit 5) clear.
- R4: Read is granted unless R6 removes it. Write is granted only when read is granted and either the page is writable or the access is supervisor with write protection off.
- R5: The page's no-execute bit counts only when the no-execute switch is on. Execute is granted when the effective no-execute bit is clear and the access is user-mode, or supervisor execute prevention is off, or the page is not a user page.
- R6: When supervisor access prevention is on, a supervisor access to a user page is granted neither read nor write.
- R7: Key rights apply only when keys are on, long mode is on, the page is a user page and `key_rights` is nonzero. The leaf key k selects bit 2k (access disable) and bit 2k+1 (write disable). Access disable removes read and write. Write disable removes write only for user accesses or when write protection is on. Execute is never removed by keys.
- R8: A read or write that the key rights alone deny faults with error bits 0 and 5 both set, whatever the other rules say.
- R9: The error code layout is: bit 0 protection, bit 1 write access, bit 2 user access, bit 3 reserved bit, bit 4 fetch, bit 5 key. Bits 1 and 2 follow the access on every response. Bit 4 is set on fetches only when no-execute together with extended paging is on, or when supervisor execute prevention is on.
- R10: A leaf that is not present faults with bit 0 clear. A leaf with a reserved bit faults with bits 0 and 3 set. Both give zero grants, and not-present takes priority.
- R11: Access type encoding is 0 read, 1 write, 2 fetch (3 is treated as read). For a present, well-formed leaf, `rsp_fault` is high exactly when the grant bit of the attempted access is zero, and then bit 0 of the error code is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access made at user privilege |
| pg_present | input | 1 | Leaf entry present |
| pg_rsvd_hit | input | 1 | Walker found a reserved bit set |
| pg_user | input | 1 | Accumulated user bit |
| pg_write | input | 1 | Accumulated writable bit |
| pg_noexec | input | 1 | Accumulated no-execute bit |
| pg_key | input | KEY_BITS | Protection key of the leaf |
| ctl_wp | input | 1 | Supervisor write protection |
| ctl_nx_en | input | 1 | No-execute bit honoured |
| ctl_ext_pg | input | 1 | Extended (64-bit entry) paging active |
| ctl_sup_exec_prot | input | 1 | Supervisor execute prevention on user pages |
| ctl_sup_acc_prot | input | 1 | Supervisor access prevention on user pages |
| ctl_key_en | input | 1 | Protection keys enabled |
| ctl_long_mode | input | 1 | Long mode active |
| key_rights | input | 2*2^KEY_BITS | Per-key access-disable / write-disable pairs |
| rsp_valid | output | 1 | Result valid |
| rsp_grant_rd | output | 1 | Read granted |
| rsp_grant_wr | output | 1 | Write granted |
| rsp_grant_ex | output | 1 | Execute granted |
| rsp_fault | output | 1 | Attempted access faults |
| rsp_err | output | 6 | Page-fault error code |

## Verification
The assertions compare the response with the inputs one cycle earlier, so they assume the request inputs are steady from the driving point up to the capturing edge. The bench meets this by changing every input on the falling edge only. The assertions also assume that `pg_rsvd_hit` is meaningful only when `pg_present` is set. The directed vectors follow that rule, and the full sweep drives only present, well-formed leaves. Key cases use a few chosen rights words and two leaf keys, not every value, so the bench stays short while still covering a selected key, an unselected key and a zero rights word.

// File: rtl/perm_pkg.sv
// Shared definitions for the page permission checker.
// Assumes: error-code bit positions are decoded by the fault handler
// downstream, so they are fixed here and nowhere else.
package perm_pkg;
    localparam int ERR_WIDTH = 6;
    localparam int ERR_PROT  = 0;
    localparam int ERR_WRITE = 1;
    localparam int ERR_USER  = 2;
    localparam int ERR_RSVD  = 3;
    localparam int ERR_FETCH = 4;
    localparam int ERR_KEY   = 5;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } grant_t;
endpackage

// File: rtl/perm_base_rules.sv
// Legacy and supervisor-protection rules: works out read/write/execute
// rights from the accumulated page bits and privilege alone.
// Assumes: inputs describe a present, well-formed leaf; the caller masks
// the result otherwise.
module perm_base_rules
    import perm_pkg::*;
(
    input  logic   is_user,
    input  logic   pg_user,
    input  logic   pg_write,
    input  logic   pg_noexec,
    input  logic   wp,
    input  logic   nx_en,
    input  logic   sup_exec_prot,
    input  logic   sup_acc_prot,
    output grant_t base,
    output logic   priv_block
);
    logic nx_eff;
    logic sup_on_user;

    // Rights from user/writable/no-execute plus supervisor protections.
    always_comb begin
        nx_eff      = pg_noexec & nx_en;
        sup_on_user = ~is_user & pg_user;
        priv_block  = is_user & ~pg_user;
        base.rd     = ~(sup_acc_prot & sup_on_user);
        base.wr     = base.rd & (pg_write | (~is_user & ~wp));
        base.ex     = ~nx_eff & (is_user | ~(sup_exec_prot & pg_user));
    end
endmodule

// File: rtl/perm_key_rules.sv
// Protection-key rule: picks the access-disable / write-disable pair of
// the leaf key and reports the rights the key leaves.
// Assumes: key_rights holds one pair per key, disable bit low, write
// disable bit high.
module perm_key_rules #(
    parameter int KEY_BITS = 4
) (
    input  logic                          key_en,
    input  logic                          long_mode,
    input  logic                          pg_user,
    input  logic                          is_user,
    input  logic                          wp,
    input  logic [KEY_BITS-1:0]           key_idx,
    input  logic [2*(1<<KEY_BITS)-1:0]    key_rights,
    output logic                          key_active,
    output logic                          key_rd_ok,
    output logic                          key_wr_ok
);
    localparam int KEY_COUNT = 1 << KEY_BITS;

    logic [KEY_COUNT-1:0] ad_vec;
    logic [KEY_COUNT-1:0] wd_vec;
    logic                 sel_ad;
    logic                 sel_wd;

    // Split the rights word into per-key disable vectors.
    for (genvar k = 0; k < KEY_COUNT; k++) begin : g_pair
        assign ad_vec[k] = key_rights[2*k];
        assign wd_vec[k] = key_rights[2*k+1];
    end

    // Gate the selected pair and derive remaining rights.
    always_comb begin
        sel_ad     = ad_vec[key_idx];
        sel_wd     = wd_vec[key_idx];
        key_active = key_en & long_mode & pg_user & (|key_rights);
        key_rd_ok  = ~(key_active & sel_ad);
        key_wr_ok  = ~(key_active & (sel_ad | (sel_wd & (is_user | wp))));
    end
endmodule

// File: rtl/perm_fault_encode.sv
// Merges base and key rights, picks the fault cause by priority and
// builds the error code.
// Assumes: rsvd_hit is only meaningful with present set; access type 3
// behaves as a read.
module perm_fault_encode
    import perm_pkg::*;
(
    input  logic [1:0]           acc,
    input  logic                 is_user,
    input  logic                 present,
    input  logic                 rsvd_hit,
    input  logic                 priv_block,
    input  grant_t               base,
    input  logic                 key_active,
    input  logic                 key_rd_ok,
    input  logic                 key_wr_ok,
    input  logic                 nx_en,
    input  logic                 ext_pg,
    input  logic                 sup_exec_prot,
    output grant_t               grant,
    output logic                 fault,
    output logic [ERR_WIDTH-1:0] err
);
    logic is_wr;
    logic is_fx;
    logic key_deny;
    logic attempted_ok;

    // Final rights, cause priority and error code assembly.
    always_comb begin
        is_wr = (acc == ACC_WRITE);
        is_fx = (acc == ACC_FETCH);

        err            = '0;
        err[ERR_WRITE] = is_wr;
        err[ERR_USER]  = is_user;
        err[ERR_FETCH] = is_fx & ((nx_en & ext_pg) | sup_exec_prot);

        if (!present || rsvd_hit || priv_block) begin
            grant = '0;
        end else begin
            grant.rd = base.rd & key_rd_ok;
            grant.wr = base.wr & key_wr_ok;
            grant.ex = base.ex;
        end

        key_deny     = key_active & (is_wr ? ~key_wr_ok : (~is_fx & ~key_rd_ok));
        attempted_ok = is_wr ? grant.wr : (is_fx ? grant.ex : grant.rd);

        fault = 1'b1;
        if (!present) begin
            fault = 1'b1;
        end else if (rsvd_hit) begin
            err[ERR_PROT] = 1'b1;
            err[ERR_RSVD] = 1'b1;
        end else if (priv_block) begin
            err[ERR_PROT] = 1'b1;
        end else if (key_deny) begin
            err[ERR_PROT] = 1'b1;
            err[ERR_KEY]  = 1'b1;
        end else if (!attempted_ok) begin
            err[ERR_PROT] = 1'b1;
        end else begin
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/page_perm_check.sv
// Page access permission checker top: evaluates one request per cycle
// and registers grants, fault flag and error code.
// Assumes: request inputs are steady around the capturing clock edge;
// results hold while req_valid is low.
module page_perm_check
    import perm_pkg::*;
#(
    parameter int KEY_BITS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_acc,
    input  logic                        req_user,
    input  logic                        pg_present,
    input  logic                        pg_rsvd_hit,
    input  logic                        pg_user,
    input  logic                        pg_write,
    input  logic                        pg_noexec,
    input  logic [KEY_BITS-1:0]         pg_key,
    input  logic                        ctl_wp,
    input  logic                        ctl_nx_en,
    input  logic                        ctl_ext_pg,
    input  logic                        ctl_sup_exec_prot,
    input  logic                        ctl_sup_acc_prot,
    input  logic                        ctl_key_en,
    input  logic                        ctl_long_mode,
    input  logic [2*(1<<KEY_BITS)-1:0]  key_rights,
    output logic                        rsp_valid,
    output logic                        rsp_grant_rd,
    output logic                        rsp_grant_wr,
    output logic                        rsp_grant_ex,
    output logic                        rsp_fault,
    output logic [ERR_WIDTH-1:0]        rsp_err
);
    grant_t               base;
    grant_t               grant;
    logic                 priv_block;
    logic                 key_active;
    logic                 key_rd_ok;
    logic                 key_wr_ok;
    logic                 fault;
    logic [ERR_WIDTH-1:0] err;

    perm_base_rules u_base (
        .is_user       (req_user),
        .pg_user       (pg_user),
        .pg_write      (pg_write),
        .pg_noexec     (pg_noexec),
        .wp            (ctl_wp),
        .nx_en         (ctl_nx_en),
        .sup_exec_prot (ctl_sup_exec_prot),
        .sup_acc_prot  (ctl_sup_acc_prot),
        .base          (base),
        .priv_block    (priv_block)
    );

    perm_key_rules #(.KEY_BITS(KEY_BITS)) u_key (
        .key_en     (ctl_key_en),
        .long_mode  (ctl_long_mode),
        .pg_user    (pg_user),
        .is_user    (req_user),
        .wp         (ctl_wp),
        .key_idx    (pg_key),
        .key_rights (key_rights),
        .key_active (key_active),
        .key_rd_ok  (key_rd_ok),
        .key_wr_ok  (key_wr_ok)
    );

    perm_fault_encode u_enc (
        .acc           (req_acc),
        .is_user       (req_user),
        .present       (pg_present),
        .rsvd_hit      (pg_rsvd_hit),
        .priv_block    (priv_block),
        .base          (base),
        .key_active    (key_active),
        .key_rd_ok     (key_rd_ok),
        .key_wr_ok     (key_wr_ok),
        .nx_en         (ctl_nx_en),
        .ext_pg        (ctl_ext_pg),
        .sup_exec_prot (ctl_sup_exec_prot),
        .grant         (grant),
        .fault         (fault),
        .err           (err)
    );

    // Valid flag: one pulse per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Result registers: load on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_grant_rd <= 1'b0;
            rsp_grant_wr <= 1'b0;
            rsp_grant_ex <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_err      <= '0;
        end else if (req_valid) begin
            rsp_grant_rd <= grant.rd;
            rsp_grant_wr <= grant.wr;
            rsp_grant_ex <= grant.ex;
            rsp_fault    <= fault;
            rsp_err      <= err;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_err) && $stable(rsp_fault)));

    p_user_sup_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pg_present && !pg_rsvd_hit && req_user && !pg_user)
        |=> (rsp_fault && rsp_err[ERR_PROT] && !rsp_err[ERR_KEY]
             && !rsp_grant_rd && !rsp_grant_wr && !rsp_grant_ex));

    p_write_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant_wr) |-> rsp_grant_rd);

    p_sup_acc_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_sup_acc_prot && !req_user && pg_user)
        |=> (!rsp_grant_rd && !rsp_grant_wr));

    p_key_implies_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err[ERR_KEY]) |-> (rsp_fault && rsp_err[ERR_PROT]));

    p_access_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_err[ERR_USER] == $past(req_user)
                       && rsp_err[ERR_WRITE] == ($past(req_acc) == ACC_WRITE)));

    p_not_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pg_present)
        |=> (rsp_fault && !rsp_err[ERR_PROT] && !rsp_grant_rd
             && !rsp_grant_wr && !rsp_grant_ex));

    p_fault_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pg_present && !pg_rsvd_hit)
        |=> (rsp_fault == rsp_err[ERR_PROT]));
endmodule

// File: tb/sim_page_perm_check.sv
// Bench: directed vector table, exhaustive sweep against a reference
// model, then reset and hold checks.
module sim_page_perm_check;
    localparam int KB = 4;
    localparam int KW = 2 * (1 << KB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_acc = '0;
    logic          req_user = 1'b0;
    logic          pg_present = 1'b0;
    logic          pg_rsvd_hit = 1'b0;
    logic          pg_user = 1'b0;
    logic          pg_write = 1'b0;
    logic          pg_noexec = 1'b0;
    logic [KB-1:0] pg_key = '0;
    logic          ctl_wp = 1'b0;
    logic          ctl_nx_en = 1'b0;
    logic          ctl_ext_pg = 1'b0;
    logic          ctl_sup_exec_prot = 1'b0;
    logic          ctl_sup_acc_prot = 1'b0;
    logic          ctl_key_en = 1'b0;
    logic          ctl_long_mode = 1'b0;
    logic [KW-1:0] key_rights = '0;
    logic          rsp_valid;
    logic          rsp_grant_rd;
    logic          rsp_grant_wr;
    logic          rsp_grant_ex;
    logic          rsp_fault;
    logic [5:0]    rsp_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    page_perm_check #(.KEY_BITS(KB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
        .req_user(req_user), .pg_present(pg_present), .pg_rsvd_hit(pg_rsvd_hit),
        .pg_user(pg_user), .pg_write(pg_write), .pg_noexec(pg_noexec),
        .pg_key(pg_key), .ctl_wp(ctl_wp), .ctl_nx_en(ctl_nx_en),
        .ctl_ext_pg(ctl_ext_pg), .ctl_sup_exec_prot(ctl_sup_exec_prot),
        .ctl_sup_acc_prot(ctl_sup_acc_prot), .ctl_key_en(ctl_key_en),
        .ctl_long_mode(ctl_long_mode), .key_rights(key_rights),
        .rsp_valid(rsp_valid), .rsp_grant_rd(rsp_grant_rd),
        .rsp_grant_wr(rsp_grant_wr), .rsp_grant_ex(rsp_grant_ex),
        .rsp_fault(rsp_fault), .rsp_err(rsp_err)
    );

    // Stimulus {present,rsvd,user,pu,pw,nx,acc[1:0],wp,nxe,epg,sxp,sap,pke,lma,-}
    // Expected {rd,wr,ex,fault,err[5:0]}
    localparam int NVEC = 8;
    localparam logic [15:0] STIM [NVEC] = '{
        16'hB800, 16'h2100, 16'hC000, 16'hA000,
        16'h9100, 16'h9180, 16'h9A10, 16'h9008};
    localparam logic [9:0] EXPV [NVEC] = '{
        10'h384, 10'h046, 10'h049, 10'h045,
        10'h382, 10'h2C3, 10'h351, 10'h0C1};

    function automatic logic [9:0] observed();
        return {rsp_grant_rd, rsp_grant_wr, rsp_grant_ex, rsp_fault, rsp_err};
    endfunction

    // Independent model of the requirements, for present well-formed leaves.
    function automatic logic [9:0] model(
        input logic [1:0] acc, input logic u, input logic pu, input logic pw,
        input logic nx, input logic [6:0] f, input logic [KW-1:0] kr,
        input logic [KB-1:0] key);
        logic rd, wr, ex, flt, act, ad, wd, deny, ok;
        logic [5:0] e;
        e = {1'b0, (acc == 2'd2) && ((f[1] && f[2]) || f[3]), 1'b0, u, acc == 2'd1, 1'b0};
        if (u && !pu) return {3'b000, 1'b1, e | 6'h01};
        rd = !(f[4] && !u && pu);
        wr = rd && (pw || (!u && !f[0]));
        ex = !(nx && f[1]) && (u || !f[3] || !pu);
        act = f[5] && f[6] && pu && (kr != '0);
        ad = kr[2*key];
        wd = kr[2*key+1];
        deny = 1'b0;
        if (act) begin
            if (ad) begin rd = 1'b0; wr = 1'b0; end
            if (wd && (u || f[0])) wr = 1'b0;
            deny = (acc == 2'd1) ? (ad || (wd && (u || f[0]))) :
                   (acc == 2'd2) ? 1'b0 : ad;
        end
        ok = (acc == 2'd1) ? wr : (acc == 2'd2) ? ex : rd;
        if (deny) begin flt = 1'b1; e = e | 6'h21; end
        else if (!ok) begin flt = 1'b1; e = e | 6'h01; end
        else flt = 1'b0;
        return {rd, wr, ex, flt, e};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [9:0] act,
                         input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on the falling edge, sample a cycle later.
    task automatic apply();
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_stim(input logic [15:0] s);
        pg_present = s[15]; pg_rsvd_hit = s[14]; req_user = s[13];
        pg_user = s[12]; pg_write = s[11]; pg_noexec = s[10]; req_acc = s[9:8];
        ctl_wp = s[7]; ctl_nx_en = s[6]; ctl_ext_pg = s[5];
        ctl_sup_exec_prot = s[4]; ctl_sup_acc_prot = s[3];
        ctl_key_en = s[2]; ctl_long_mode = s[1];
    endtask

    initial begin
        logic [9:0] hold;
        // R1: reset state with a request driven during reset.
        req_valid = 1'b1;
        load_stim(16'hB800);
        repeat (3) @(negedge clk);
        check(!rsp_valid && observed() == '0, "R1 reset", observed(), '0);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Directed table: R3 R4 R5 R6 R9 R10 R11.
        for (int i = 0; i < NVEC; i++) begin
            load_stim(STIM[i]);
            apply();
            check(rsp_valid, "R2 valid", {9'd0, rsp_valid}, 10'd1);
            check(observed() == EXPV[i], $sformatf("R10/R11 table %0d", i),
                  observed(), EXPV[i]);
        end

        // R2: outputs hold while idle.
        hold = observed();
        load_stim(16'hB800);
        @(negedge clk);
        @(negedge clk);
        check(!rsp_valid && observed() == hold, "R2 hold", observed(), hold);

        // R8: key write-disable on user write gives protection and key bits.
        load_stim(16'hB906);
        pg_key = 4'd5; key_rights = 'h800;
        apply();
        check(observed() == 10'h2E7, "R8 key deny", observed(), 10'h2E7);

        // R7: same rights word, long mode off -> key has no effect.
        ctl_long_mode = 1'b0;
        apply();
        check(observed() == 10'h386, "R7 key gated", observed(), 10'h386);

        // Full sweep: R3 R4 R5 R6 R7 R8 R9 R11.
        for (int kp = 0; kp < 4; kp++) begin
            for (int lk = 0; lk < 2; lk++) begin
                for (int f = 0; f < 128; f++) begin
                    for (int b = 0; b < 16; b++) begin
                        for (int a = 0; a < 3; a++) begin
                            logic [KW-1:0] kr;
                            logic [9:0] exp;
                            kr = (kp == 0) ? 'h0 : (kp == 1) ? 'h400 :
                                 (kp == 2) ? 'h800 : 'hC80;
                            pg_present = 1'b1; pg_rsvd_hit = 1'b0;
                            req_acc = 2'(a); req_user = b[0]; pg_user = b[1];
                            pg_write = b[2]; pg_noexec = b[3];
                            ctl_wp = f[0]; ctl_nx_en = f[1]; ctl_ext_pg = f[2];
                            ctl_sup_exec_prot = f[3]; ctl_sup_acc_prot = f[4];
                            ctl_key_en = f[5]; ctl_long_mode = f[6];
                            key_rights = kr;
                            pg_key = (lk == 0) ? 4'd5 : 4'd3;
                            exp = model(2'(a), b[0], b[1], b[2], b[3], 7'(f), kr,
                                        pg_key);
                            apply();
                            check(observed() == exp, "R11 sweep", observed(), exp);
                        end
                    end
                end
            end
        end

        // R1: reset in mid-run clears a faulting result.
        load_stim(16'hA000);
        apply();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!rsp_valid && observed() == '0, "R1 mid reset", observed(), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule